// File: doc/BRIEF.md
# Periodic Pulse-Swallow Corrector

This stage sits in the once-per-second drive path of a timekeeping circuit whose crystal is deliberately trimmed to run slightly fast. Every second tick from the upstream divider normally passes straight through to the motor. A presettable down-counter, stepped once per tick, measures a correction interval. When that interval runs out, exactly one motor pulse is withheld, so the average pulse rate drops to the nominal one.

The tick input is a one-cycle enable strobe that is synchronous to the system clock. The counter, the zero detect and the output gating all run on that clock. A preset near 36000 removes about one pulse every ten hours. With a preset of P, the corrector passes P ticks and then swallows the next one, so the pattern repeats every P+1 ticks. A preset of zero turns correction off.

Top module: `pulse_swallow_corrector`

## Requirements
- R1: While `rst` is high, both outputs are low and the interval counter is loaded from `presetVal`. After release, the first swallow happens on tick number `presetVal`+1.
- R2: A tick that arrives while the counter is non-zero is passed on. `motorPulse` is high for exactly the one clock cycle after the cycle in which `tickIn` was high.
- R3: Each passed tick lowers the counter by exactly one. Without a tick the counter holds its value.
- R4: A tick that arrives while the counter is zero and `presetVal` is non-zero is swallowed. `motorPulse` stays low and `swallowFlag` is high for the one cycle after that tick.
- R5: On a swallow, the counter reloads `presetVal`. With a fixed preset P, one tick in every P+1 is removed.
- R6: With `presetVal` equal to zero, no tick is ever swallowed.
- R7: A change of `presetVal` takes effect only at the next reload or reset. The interval already in progress finishes with its old count.
- R8: Neither output is high unless `tickIn` was high in the previous cycle, and `motorPulse` and `swallowFlag` are never high together.
- R9: The zero detect covers every counter bit, so a preset of 36000 gives exactly 36000 passed ticks before the swallow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; loads the counter from the preset |
| tickIn | input | 1 | One-cycle strobe, once per second |
| presetVal | input | CNT_W (16) | Correction interval in ticks; zero disables swallowing |
| motorPulse | output | 1 | One-cycle motor pulse for each tick that is passed |
| swallowFlag | output | 1 | One-cycle flag for each tick that is removed |

## Verification
The in-line properties check, on every cycle, the following:
- the outputs are mutually exclusive and never occur without a tick (R8);
- every tick produces exactly one of the two outputs (R2);
- the counter steps down by one or holds (R3);
- a reload takes the preset value (R5);
- no swallow happens under a zero preset (R6).

Only the bench scenarios can show where in the tick sequence a swallow falls. This covers the first interval after reset, the repeating P+1 pattern, a preset changed in the middle of an interval, and the full 36000-tick interval.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  // strobes from the control decision to the counting datapath
  typedef struct packed {
    logic passTick;     // forward this tick to the motor
    logic swallowTick;  // remove this tick
    logic reload;       // reload the interval counter from the preset
    logic decrement;    // step the interval counter down by one
  } swallowStrobes_t;
endpackage

// File: rtl/swallow_control.sv
module swallow_control
  import swallow_pkg::*;
(
  input  logic            tickIn,
  input  logic            cntZero,
  input  logic            presetZero,
  output swallowStrobes_t strobes
);
  logic swallowNow;

  always_comb begin
    swallowNow          = tickIn && cntZero && !presetZero;
    strobes.swallowTick = swallowNow;
    strobes.passTick    = tickIn && !swallowNow;
    strobes.reload      = tickIn && cntZero;
    strobes.decrement   = tickIn && !cntZero;
  end
endmodule

// File: rtl/swallow_datapath.sv
module swallow_datapath
  import swallow_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NOR_GROUP = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] presetIn,
  input  swallowStrobes_t  strobes,
  output logic             cntZero,
  output logic             presetZero,
  output logic             motorPulse,
  output logic             swallowFlag
);
  localparam int NUM_GROUPS = (CNT_W + NOR_GROUP - 1) / NOR_GROUP;

  logic [CNT_W-1:0]      cnt;
  logic [NUM_GROUPS-1:0] groupAny;

  // interval counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= presetIn;
    end else if (strobes.reload) begin
      cnt <= presetIn;
    end else if (strobes.decrement) begin
      cnt <= cnt - 1'b1;
    end
  end

  // wide NOR zero detect, built from small OR groups
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_zeroGroup
    localparam int LO = g * NOR_GROUP;
    localparam int HI = (LO + NOR_GROUP - 1 < CNT_W) ? LO + NOR_GROUP - 1 : CNT_W - 1;
    assign groupAny[g] = |cnt[HI:LO];
  end

  assign cntZero    = ~|groupAny;
  assign presetZero = ~|presetIn;

  // registered output gating
  always_ff @(posedge clk) begin
    if (rst) begin
      motorPulse  <= 1'b0;
      swallowFlag <= 1'b0;
    end else begin
      motorPulse  <= strobes.passTick;
      swallowFlag <= strobes.swallowTick;
    end
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.decrement) && !$past(rst)) |-> (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.reload) && !$past(strobes.decrement)) |-> $stable(cnt));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.reload) && !$past(rst)) |-> (cnt == $past(presetIn)));
endmodule

// File: rtl/pulse_swallow_corrector.sv
module pulse_swallow_corrector
  import swallow_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NOR_GROUP = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             tickIn,
  input  logic [CNT_W-1:0] presetVal,
  output logic             motorPulse,
  output logic             swallowFlag
);
  swallowStrobes_t strobes;
  logic            cntZero;
  logic            presetZero;

  swallow_control i_control (
    .tickIn     (tickIn),
    .cntZero    (cntZero),
    .presetZero (presetZero),
    .strobes    (strobes)
  );

  swallow_datapath #(
    .CNT_W     (CNT_W),
    .NOR_GROUP (NOR_GROUP)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .presetIn    (presetVal),
    .strobes     (strobes),
    .cntZero     (cntZero),
    .presetZero  (presetZero),
    .motorPulse  (motorPulse),
    .swallowFlag (swallowFlag)
  );

  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(motorPulse && swallowFlag));

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (motorPulse || swallowFlag) |-> $past(tickIn));

  // R2
  tick_served_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tickIn) && !$past(rst)) |-> (motorPulse || swallowFlag));

  // R6
  zero_preset_chk: assert property (@(posedge clk) disable iff (rst)
    swallowFlag |-> ($past(presetVal) != '0));
endmodule

// File: tb/test_pulse_swallow_corrector.sv
`timescale 1ns/1ps
module test_pulse_swallow_corrector;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tickIn = 1'b0;
  logic [CNT_W-1:0] presetVal = '0;
  logic             motorPulse;
  logic             swallowFlag;

  int checks = 0;
  int errors = 0;
  int mCnt = 0;
  int swallows = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_swallow_corrector #(.CNT_W(CNT_W)) i_pulse_swallow_corrector (
    .clk(clk), .rst(rst), .tickIn(tickIn), .presetVal(presetVal),
    .motorPulse(motorPulse), .swallowFlag(swallowFlag)
  );

  // expected output pair {motorPulse, swallowFlag} for a tick, from the requirements
  function automatic logic [1:0] expectTick(int cnt, int preset);
    if (cnt == 0 && preset != 0) return 2'b01;
    return 2'b10;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {motor,swallow}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(int preset);
    rst = 1'b1;
    tickIn = 1'b0;
    presetVal = CNT_W'(preset);
    repeat (3) @(negedge clk);
    check("R1", {motorPulse, swallowFlag}, 2'b00);
    rst = 1'b0;
    mCnt = preset;
  endtask

  // one tick followed by gap idle cycles; tag empty means pick R2/R4 by outcome
  task automatic doTick(int gap, string tag);
    logic [1:0] exp;
    exp = expectTick(mCnt, int'(presetVal));
    if (mCnt == 0) mCnt = int'(presetVal);
    else mCnt--;
    if (exp == 2'b01) swallows++;
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    if (tag != "") check(tag, {motorPulse, swallowFlag}, exp);
    else check(exp == 2'b01 ? "R4" : "R2", {motorPulse, swallowFlag}, exp);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R8", {motorPulse, swallowFlag}, 2'b00);
    end
  endtask

  initial begin
    void'($urandom(32'd20231));
    @(negedge clk);

    // R1: first swallow after preset passes
    doReset(3);
    for (int i = 0; i < 3; i++) doTick(1, "R1");
    doTick(2, "R4");
    // R5: repeating pattern, one in four removed
    for (int i = 0; i < 3; i++) doTick(0, "R3");
    doTick(0, "R5");
    for (int i = 0; i < 3; i++) doTick(0, "R5");
    doTick(3, "R5");

    // preset of one alternates pass and swallow
    doReset(1);
    for (int i = 0; i < 8; i++) doTick(i % 2, "R5");

    // R6: zero preset never swallows
    doReset(0);
    for (int i = 0; i < 20; i++) doTick(i % 3, "R6");

    // R7: preset change mid-interval
    doReset(5);
    doTick(1, "R7");
    doTick(1, "R7");
    presetVal = CNT_W'(2);
    for (int i = 0; i < 3; i++) doTick(1, "R7");
    doTick(1, "R7");
    for (int i = 0; i < 2; i++) doTick(1, "R7");
    doTick(1, "R7");

    // R8: idle with no tick
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8", {motorPulse, swallowFlag}, 2'b00);
    end

    // random presets and gaps
    doReset(int'($urandom_range(6, 1)));
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(19, 0) == 0) presetVal = CNT_W'($urandom_range(6, 0));
      doTick(int'($urandom_range(2, 0)), "");
    end

    // R9: full ten-hour interval
    doReset(36000);
    swallows = 0;
    for (int i = 0; i < 36000; i++) doTick(0, "R9");
    doTick(1, "R9");
    checks++;
    if (swallows != 1) begin
      errors++;
      $display("FAIL R9: swallow count %0d expected 1", swallows);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule